// File: doc/BRIEF.md
# Arithmetic Operational Register with Overflow Flag

This block is an 8-bit operational register whose next value is picked by a 2-bit operation code. It can keep its contents, double them by a left shift, take the sum of two operand inputs, or take their difference. A synchronous active-low reset clears the stored value and takes priority over any operation. A shared ripple-carry adder/subtractor produces the arithmetic result. A per-bit selection cell in front of each storage flop chooses between the held bit, the shifted-in bit and the adder bit.

Three status outputs describe the register. Two are decoded from the stored word: one says it is zero, the other says it is negative. The third is a separate flop that records whether the most recent state-changing operation stayed inside the signed range. A controller uses it to tell whether the current contents can be trusted. Holding leaves that flag untouched.

Top module: `opreg_top`

## Requirements
- R1: When rst_ni is 0 at a rising clock edge, y_o becomes 0 and valid_o becomes 1 at that edge, whatever op_i is.
- R2: op_i = 2'b00 (hold) leaves y_o and valid_o unchanged across the edge.
- R3: op_i = 2'b01 loads y_o shifted left by one bit, with 0 entering bit 0 and the old bit 7 discarded.
- R4: op_i = 2'b10 loads (a_i + b_i) modulo 256.
- R5: op_i = 2'b11 loads (a_i - b_i) modulo 256.
- R6: zero_o is 1 exactly when the stored value is 0.
- R7: neg_o equals the most significant bit of the stored value, which is the two's-complement sign.
- R8: After op 2'b10 or 2'b11, valid_o is 0 if the signed 8-bit result overflowed (the true result lies outside -128..127) and 1 otherwise.
- R9: After op 2'b01, valid_o is 0 if the shift changed the sign bit (old bits 7 and 6 differ) and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| op_i | input | 2 | Operation: 00 hold, 01 shift left, 10 add, 11 subtract |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand (subtrahend for 11) |
| y_o | output | 8 | Stored register value |
| zero_o | output | 1 | Stored value is all zeros |
| neg_o | output | 1 | Stored value is negative |
| valid_o | output | 1 | Last state-changing operation did not overflow |

## Verification
The properties assume that op_i, a_i and b_i are defined and steady around each rising edge. They also assume that reset is held low from time zero until the first edge, so that every comparison against a past value starts from a known word. The stimulus changes inputs only on falling edges and drives reset low from the start. It mixes directed boundary operands (127+1, -128-1, equal operands, shifts across bit 6 and bit 7, reset during an operation, hold after an overflow) with a long run of random operations and occasional resets.

// File: rtl/opreg_pkg.sv
package opreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_SHL  = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } op_e;
endpackage

// File: rtl/opreg_addsub.sv
module opreg_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W:0]   c;
  logic [W-1:0] bx;

  assign c[0] = sub_i;
  assign bx   = b_i ^ {W{sub_i}};

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ bx[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & bx[i]) | (c[i] & (a_i[i] ^ bx[i]));
  end

  // signed overflow: carry into sign differs from carry out
  assign ovf_o = c[W] ^ c[W-1];
endmodule

// File: rtl/opreg_cell.sv
module opreg_cell
  import opreg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic shin_i,
  input  logic sum_i,
  output logic q_o
);
  logic d;

  always_comb begin
    unique case (op_i)
      OP_HOLD: d = q_o;
      OP_SHL:  d = shin_i;
      default: d = sum_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/opreg_top.sv
module opreg_top
  import opreg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         valid_o
);
  localparam int unsigned MSB = W - 1;

  op_e          op;
  logic [W-1:0] y_q;
  logic [W-1:0] shin;
  logic [W-1:0] sum;
  logic         ovf_arith;
  logic         ovf_sel;
  logic         valid_q;

  assign op   = op_e'(op_i);
  assign shin = {y_q[MSB-1:0], 1'b0};

  opreg_addsub #(.W(W)) i_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op_i[0]),
    .sum_o (sum),
    .ovf_o (ovf_arith)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    opreg_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op),
      .shin_i (shin[i]),
      .sum_i  (sum[i]),
      .q_o    (y_q[i])
    );
  end

  always_comb begin
    unique case (op)
      OP_SHL:         ovf_sel = y_q[MSB] ^ y_q[MSB-1];
      OP_ADD, OP_SUB: ovf_sel = ovf_arith;
      default:        ovf_sel = 1'b0;
    endcase
  end

  // flag only moves when the word is rewritten
  always_ff @(posedge clk_i) begin
    if (!rst_ni)             valid_q <= 1'b1;
    else if (op != OP_HOLD)  valid_q <= ~ovf_sel;
  end

  assign y_o     = y_q;
  assign zero_o  = ~|y_q;
  assign neg_o   = y_q[MSB];
  assign valid_o = valid_q;
endmodule

// File: rtl/opreg_chk.sv
module opreg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] y_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         valid_o
);
  a_r1_reset: assert property (@(posedge clk_i)
    !rst_ni |=> (y_o == '0 && valid_o));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b00 |=> ($stable(y_o) && $stable(valid_o)));

  a_r3_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b01 |=> y_o == {$past(y_o[W-2:0]), 1'b0});

  a_r4_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b10 |=> y_o == W'($past(a_i) + $past(b_i)));

  a_r5_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b11 |=> y_o == W'($past(a_i) - $past(b_i)));

  a_r6_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b11 |=> zero_o == ($past(a_i) == $past(b_i)));

  a_r7_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b01 |=> neg_o == $past(y_o[W-2]));

  a_r8_add_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b10 |=> valid_o == !(($past(a_i[W-1]) == $past(b_i[W-1])) &&
                                   (y_o[W-1] != $past(a_i[W-1]))));

  a_r8_sub_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b11 |=> valid_o == !(($past(a_i[W-1]) != $past(b_i[W-1])) &&
                                   (y_o[W-1] != $past(a_i[W-1]))));

  a_r9_shift_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b01 |=> valid_o == ($past(y_o[W-1]) == $past(y_o[W-2])));
endmodule

bind opreg_top opreg_chk #(.W(W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .y_o     (y_o),
  .zero_o  (zero_o),
  .neg_o   (neg_o),
  .valid_o (valid_o)
);

// File: tb/test_opreg_top.sv
module test_opreg_top;
  localparam int W = 8;
  localparam int M = 2 ** W;

  logic         clk_i  = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   op_i   = 2'b00;
  logic [W-1:0] a_i    = '0;
  logic [W-1:0] b_i    = '0;
  logic [W-1:0] y_o;
  logic         zero_o, neg_o, valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int my = 0;
  int mv = 1;

  always #2 clk_i = ~clk_i;

  opreg_top #(.W(W)) i_opreg_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .y_o(y_o), .zero_o(zero_o), .neg_o(neg_o), .valid_o(valid_o)
  );

  function automatic int sgn(input int x);
    return (x >= M / 2) ? x - M : x;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input bit rn, input logic [1:0] op,
                      input int a, input int b);
    int r;
    string ty, tv;
    rst_ni = rn; op_i = op; a_i = W'(a); b_i = W'(b);
    @(posedge clk_i);
    if (!rn) begin
      my = 0; mv = 1; ty = "R1"; tv = "R1";
    end else begin
      case (op)
        2'b00: begin r = sgn(my); ty = "R2"; tv = "R2"; end
        2'b01: begin r = 2 * sgn(my); ty = "R3"; tv = "R9"; end
        2'b10: begin r = sgn(a) + sgn(b); ty = "R4"; tv = "R8"; end
        default: begin r = sgn(a) - sgn(b); ty = "R5"; tv = "R8"; end
      endcase
      if (op != 2'b00) begin
        my = ((r % M) + M) % M;
        mv = (r >= -(M / 2) && r < M / 2) ? 1 : 0;
      end
    end
    @(negedge clk_i);
    chk(ty, int'(y_o), my);
    chk("R6", int'(zero_o), (my == 0) ? 1 : 0);
    chk("R7", int'(neg_o), (my >= M / 2) ? 1 : 0);
    chk(tv, int'(valid_o), mv);
  endtask

  initial begin
    @(negedge clk_i);
    step(0, 2'b10, 5, 6);          // R1 reset beats add
    step(1, 2'b10, 127, 1);        // R8 positive overflow
    step(1, 2'b00, 3, 3);          // R2 hold keeps invalid flag
    step(1, 2'b11, 128, 1);        // R5 -128-1 overflow
    step(1, 2'b11, 77, 77);        // R6 zero result
    step(1, 2'b10, 64, 0);         // R4 load 0x40
    step(1, 2'b01, 0, 0);          // R9 0x40 -> 0x80 sign change
    step(1, 2'b01, 0, 0);          // R3 0x80 -> 0x00
    step(1, 2'b10, 200, 100);      // R4 wrap, no signed overflow
    step(1, 2'b01, 0, 0);          // R3 shift
    step(0, 2'b01, 0, 0);          // R1 reset during shift
    step(1, 2'b11, 0, 128);        // R8 0-(-128) overflow
    step(1, 2'b10, 255, 1);        // R8 -1+1 = 0 valid
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 25) != 0, 2'(($urandom % 4)),
           int'($urandom % M), int'($urandom % M));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule